// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block advances a dot position by one on every clock and tracks which line of the raster the beam is on, plus a count of finished frames. A renderer takes the dot and line counts as its position. When the line count reaches the first vertical-blank line, the block sets a blanking flag and gives a one-clock frame-done strobe. If software has enabled it, the block also gives a one-clock interrupt request to the processor. After the last line, the flag clears, the line count returns to zero and the frame count advances.

The processor reaches the block through a small byte-wide register port. It can make one write: bit 7 of that write arms or disarms the interrupt request. It can make two reads. One returns the blanking flag. The other returns the vertical and horizontal blanking indications together in one byte. All timing points and addresses are parameters. The defaults give 340 dots per line, blanking from line 225, and a frame of 260 lines.

Top module: `raster_timing_gen`

## Requirements
- R1: Synchronous active-low reset. While rst_n is low at a clock edge, the outputs clear: dot count, line count, frame count, blanking flag and interrupt enable go to zero, and frame_done and nmi_req go low.
- R2: Each clock after reset, dot_cnt goes up by one. From DOT_LAST (default 340) it goes to 1, not 0. So after reset it runs 1..DOT_LAST and repeats.
- R3: The line count goes up by one on the clock where dot_cnt leaves DOT_LAST. When it would reach LINE_WRAP (default 260), it goes to 0 instead, and frame_cnt goes up by one, wrapping modulo 2^FRAME_W.
- R4: vblank goes to 1 on the clock that takes the line count to VBL_LINE (default 225). It goes back to 0 on the clock where the line count wraps to 0.
- R5: frame_done is high for exactly one clock. That clock is the first one on which line_cnt equals VBL_LINE.
- R6: nmi_req is high for exactly one clock, in the same clock as frame_done. It fires only if the interrupt enable was already set before the clock edge that enters VBL_LINE. A write on that same edge acts from the next event on.
- R7: A write to CTRL_ADDR (default 0x4200) loads the interrupt enable from wr_data bit 7. The other data bits have no effect, and neither do writes to any other address.
- R8: Reading NMI_STAT_ADDR (default 0x4210) returns 0x80 while vblank is 1, and 0x00 otherwise.
- R9: Reading BLANK_STAT_ADDR (default 0x4212) returns bit 7 = (line_cnt >= VBL_LINE). Bit 6 = (dot_cnt >= HBL_START or dot_cnt <= HBL_END), with defaults 0x121 and 0x15. Both bits can be 1 at once, and bits 5..0 are 0.
- R10: Reading any other address, CTRL_ADDR included, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock, one dot per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 16 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| dot_cnt | output | DOT_W | Current dot within the line |
| line_cnt | output | LINE_W | Current line within the frame |
| frame_cnt | output | FRAME_W | Completed frame count |
| vblank | output | 1 | Vertical blanking flag |
| frame_done | output | 1 | One-clock strobe at blanking entry |
| nmi_req | output | 1 | One-clock interrupt request at blanking entry |

## Verification
The hardest case to reach from the ports is a write to the enable register that lands on the exact edge entering the blanking line. Only this case shows that the request uses the enable value from before that edge. A second hard case is the frame counter wrap, which with default sizes would take years of simulation.

The bench runs a shrunk instance: 12 dots per line, 8 lines, blanking from line 5, and a 2-bit frame counter. Its writes are scheduled by step number so that they land on the blanking-entry edges of chosen frames. It compares every dot of five frames, plus a mid-run reset, against an arithmetic model, and it reads every status address on every step. A default-sized instance is then run for one full frame to confirm where the real event points fall.

// File: rtl/raster_timing_pkg.sv
// Package: raster_timing_pkg
// Shared register addresses and the event record that passes between the line
// sequencer and the status logic. Assumes 16-bit register addresses.
package raster_timing_pkg;

    localparam logic [15:0] DEF_CTRL_ADDR       = 16'h4200;
    localparam logic [15:0] DEF_NMI_STAT_ADDR   = 16'h4210;
    localparam logic [15:0] DEF_BLANK_STAT_ADDR = 16'h4212;

    // Bit positions inside the status bytes read by software.
    localparam int STAT_VBL_BIT = 7;
    localparam int STAT_HBL_BIT = 6;
    localparam int CTRL_EN_BIT  = 7;

    // Events raised by the line sequencer on a line boundary.
    typedef struct packed {
        logic enter_vbl;
        logic wrap;
    } line_evt_t;

endpackage

// File: rtl/raster_dot_ctr.sv
// Module: raster_dot_ctr
// Counts dots within a line. After reset the count is 0; each clock it
// advances, and from DOT_LAST it returns to 1 (the zero state is skipped).
// Assumes DOT_LAST >= 2.
module raster_dot_ctr #(
    parameter int DOT_LAST = 340,
    localparam int DOT_W   = $clog2(DOT_LAST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [DOT_W-1:0] dot,
    output logic             line_end
);

    // Last dot of the line is reached.
    assign line_end = (dot == DOT_W'(DOT_LAST));

    // Advance the dot, folding DOT_LAST back to 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dot <= '0;
        end else if (line_end) begin
            dot <= DOT_W'(1);
        end else begin
            dot <= dot + DOT_W'(1);
        end
    end

endmodule

// File: rtl/raster_line_seq.sv
// Module: raster_line_seq
// Steps the line and frame counters on each line_end. It raises the blanking
// flag and the frame-done and interrupt strobes at VBL_LINE, and clears the
// flag at the frame wrap. Assumes 0 < VBL_LINE < LINE_WRAP.
module raster_line_seq
    import raster_timing_pkg::*;
#(
    parameter int VBL_LINE  = 225,
    parameter int LINE_WRAP = 260,
    parameter int FRAME_W   = 32,
    localparam int LINE_W   = $clog2(LINE_WRAP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               line_end,
    input  logic               nmi_en,
    output logic [LINE_W-1:0]  line,
    output logic [FRAME_W-1:0] frame,
    output logic               vbl_flag,
    output logic               frame_done,
    output logic               nmi_req
);

    logic [LINE_W-1:0] line_nxt;
    line_evt_t         evt;

    // Work out the candidate next line and which boundary it represents.
    always_comb begin
        line_nxt      = line + LINE_W'(1);
        evt.wrap      = line_end && (line_nxt == LINE_W'(LINE_WRAP));
        evt.enter_vbl = line_end && (line_nxt == LINE_W'(VBL_LINE));
    end

    // Update counters, flag and one-clock strobes on line boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line       <= '0;
            frame      <= '0;
            vbl_flag   <= 1'b0;
            frame_done <= 1'b0;
            nmi_req    <= 1'b0;
        end else begin
            frame_done <= evt.enter_vbl;
            nmi_req    <= evt.enter_vbl && nmi_en;
            if (evt.wrap) begin
                line     <= '0;
                frame    <= frame + FRAME_W'(1);
                vbl_flag <= 1'b0;
            end else if (line_end) begin
                line <= line_nxt;
                if (evt.enter_vbl) begin
                    vbl_flag <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/raster_status_regs.sv
// Module: raster_status_regs
// Holds the interrupt enable bit (loaded by writes to CTRL_ADDR) and returns
// the status bytes. Reads are combinational and have no side effects.
module raster_status_regs
    import raster_timing_pkg::*;
#(
    parameter int          DOT_LAST        = 340,
    parameter int          VBL_LINE        = 225,
    parameter int          LINE_WRAP       = 260,
    parameter int          HBL_START       = 'h121,
    parameter int          HBL_END         = 'h15,
    parameter logic [15:0] CTRL_ADDR       = DEF_CTRL_ADDR,
    parameter logic [15:0] NMI_STAT_ADDR   = DEF_NMI_STAT_ADDR,
    parameter logic [15:0] BLANK_STAT_ADDR = DEF_BLANK_STAT_ADDR,
    localparam int DOT_W  = $clog2(DOT_LAST + 1),
    localparam int LINE_W = $clog2(LINE_WRAP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       rd_addr,
    input  logic [DOT_W-1:0]  dot,
    input  logic [LINE_W-1:0] line,
    input  logic              vbl_flag,
    output logic              nmi_en,
    output logic [7:0]        rd_data
);

    logic hbl_win;
    logic vbl_zone;

    // Horizontal window wraps around the line boundary; vertical is a threshold.
    always_comb begin
        hbl_win  = (32'(dot) >= HBL_START) || (32'(dot) <= HBL_END);
        vbl_zone = (32'(line) >= VBL_LINE);
    end

    // Capture the enable bit from control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_en <= 1'b0;
        end else if (wr_en && (wr_addr == CTRL_ADDR)) begin
            nmi_en <= wr_data[CTRL_EN_BIT];
        end
    end

    // Read multiplexer; both blanking bits are merged bitwise.
    always_comb begin
        rd_data = 8'h00;
        if (rd_addr == NMI_STAT_ADDR) begin
            rd_data[STAT_VBL_BIT] = vbl_flag;
        end else if (rd_addr == BLANK_STAT_ADDR) begin
            rd_data[STAT_VBL_BIT] = vbl_zone;
            rd_data[STAT_HBL_BIT] = hbl_win;
        end
    end

endmodule

// File: rtl/raster_timing_gen.sv
// Module: raster_timing_gen (top)
// Raster dot/line/frame timing with a blanking flag, frame-done strobe, gated
// interrupt strobe and a byte-wide status/control register port. One dot per
// clock edge. All registers use a synchronous active-low reset.
module raster_timing_gen
    import raster_timing_pkg::*;
#(
    parameter int          DOT_LAST        = 340,
    parameter int          VBL_LINE        = 225,
    parameter int          LINE_WRAP       = 260,
    parameter int          HBL_START       = 'h121,
    parameter int          HBL_END         = 'h15,
    parameter int          FRAME_W         = 32,
    parameter logic [15:0] CTRL_ADDR       = DEF_CTRL_ADDR,
    parameter logic [15:0] NMI_STAT_ADDR   = DEF_NMI_STAT_ADDR,
    parameter logic [15:0] BLANK_STAT_ADDR = DEF_BLANK_STAT_ADDR,
    localparam int DOT_W  = $clog2(DOT_LAST + 1),
    localparam int LINE_W = $clog2(LINE_WRAP + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [15:0]        rd_addr,
    output logic [7:0]         rd_data,
    output logic [DOT_W-1:0]   dot_cnt,
    output logic [LINE_W-1:0]  line_cnt,
    output logic [FRAME_W-1:0] frame_cnt,
    output logic               vblank,
    output logic               frame_done,
    output logic               nmi_req
);

    logic line_end;
    logic nmi_en;

    raster_dot_ctr #(.DOT_LAST(DOT_LAST)) dot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .dot      (dot_cnt),
        .line_end (line_end)
    );

    raster_line_seq #(
        .VBL_LINE  (VBL_LINE),
        .LINE_WRAP (LINE_WRAP),
        .FRAME_W   (FRAME_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_end   (line_end),
        .nmi_en     (nmi_en),
        .line       (line_cnt),
        .frame      (frame_cnt),
        .vbl_flag   (vblank),
        .frame_done (frame_done),
        .nmi_req    (nmi_req)
    );

    raster_status_regs #(
        .DOT_LAST        (DOT_LAST),
        .VBL_LINE        (VBL_LINE),
        .LINE_WRAP       (LINE_WRAP),
        .HBL_START       (HBL_START),
        .HBL_END         (HBL_END),
        .CTRL_ADDR       (CTRL_ADDR),
        .NMI_STAT_ADDR   (NMI_STAT_ADDR),
        .BLANK_STAT_ADDR (BLANK_STAT_ADDR)
    ) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .dot      (dot_cnt),
        .line     (line_cnt),
        .vbl_flag (vblank),
        .nmi_en   (nmi_en),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/raster_timing_chk.sv
// Module: raster_timing_chk
// Property checker bound to raster_timing_gen. Observes ports only.
module raster_timing_chk #(
    parameter int          DOT_LAST        = 340,
    parameter int          VBL_LINE        = 225,
    parameter int          LINE_WRAP       = 260,
    parameter int          FRAME_W         = 32,
    parameter logic [15:0] NMI_STAT_ADDR   = 16'h4210,
    parameter logic [15:0] BLANK_STAT_ADDR = 16'h4212,
    localparam int DOT_W  = $clog2(DOT_LAST + 1),
    localparam int LINE_W = $clog2(LINE_WRAP + 1)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        rd_addr,
    input logic [7:0]         rd_data,
    input logic [DOT_W-1:0]   dot_cnt,
    input logic [LINE_W-1:0]  line_cnt,
    input logic [FRAME_W-1:0] frame_cnt,
    input logic               vblank,
    input logic               frame_done,
    input logic               nmi_req
);

    assert_dot_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        32'(dot_cnt) <= DOT_LAST);

    assert_dot_fold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dot_cnt) == DOT_W'(DOT_LAST)) |-> dot_cnt == DOT_W'(1));

    assert_frame_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && frame_cnt != $past(frame_cnt))
            |-> (line_cnt == '0 && frame_cnt == $past(frame_cnt) + FRAME_W'(1)));

    assert_line_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(line_cnt) < LINE_WRAP);

    assert_vbl_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vblank) |-> (line_cnt == LINE_W'(VBL_LINE) && frame_done));

    assert_vbl_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vblank) |-> line_cnt == '0);

    assert_fd_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    assert_nmi_with_fd_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> frame_done);

    assert_nmi_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |=> !nmi_req);

    assert_nmi_stat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == NMI_STAT_ADDR) |-> rd_data == (vblank ? 8'h80 : 8'h00));

    assert_blank_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == BLANK_STAT_ADDR)
            |-> (rd_data[7] == (32'(line_cnt) >= VBL_LINE) && rd_data[5:0] == 6'd0));

endmodule

bind raster_timing_gen raster_timing_chk #(
    .DOT_LAST        (DOT_LAST),
    .VBL_LINE        (VBL_LINE),
    .LINE_WRAP       (LINE_WRAP),
    .FRAME_W         (FRAME_W),
    .NMI_STAT_ADDR   (NMI_STAT_ADDR),
    .BLANK_STAT_ADDR (BLANK_STAT_ADDR)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .dot_cnt    (dot_cnt),
    .line_cnt   (line_cnt),
    .frame_cnt  (frame_cnt),
    .vblank     (vblank),
    .frame_done (frame_done),
    .nmi_req    (nmi_req)
);

// File: tb/raster_timing_gen_tb_top.sv
// Bench: a shrunk instance swept dot by dot against an arithmetic model,
// then a default-sized instance checked at its real event points.
module raster_timing_gen_tb_top;

    localparam int SD_LAST  = 12;
    localparam int SV_LINE  = 5;
    localparam int SL_WRAP  = 8;
    localparam int SH_START = 10;
    localparam int SH_END   = 2;
    localparam int SF_W     = 2;
    localparam int STEPS_PER_FRAME = SD_LAST * SL_WRAP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    // Shrunk instance
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] rd_addr = '0;
    logic [7:0]  rd_data;
    logic [3:0]  dot_cnt;
    logic [3:0]  line_cnt;
    logic [1:0]  frame_cnt;
    logic        vblank, frame_done, nmi_req;

    raster_timing_gen #(
        .DOT_LAST(SD_LAST), .VBL_LINE(SV_LINE), .LINE_WRAP(SL_WRAP),
        .HBL_START(SH_START), .HBL_END(SH_END), .FRAME_W(SF_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .dot_cnt(dot_cnt), .line_cnt(line_cnt), .frame_cnt(frame_cnt),
        .vblank(vblank), .frame_done(frame_done), .nmi_req(nmi_req)
    );

    // Default-sized instance
    logic        d_wr_en = 1'b0;
    logic [15:0] d_wr_addr = '0;
    logic [7:0]  d_wr_data = '0;
    logic [15:0] d_rd_addr = 16'h4212;
    logic [7:0]  d_rd_data;
    logic [8:0]  d_dot;
    logic [8:0]  d_line;
    logic [31:0] d_frame;
    logic        d_vbl, d_fd, d_nmi;

    raster_timing_gen dflt_i (
        .clk(clk), .rst_n(rst_n), .wr_en(d_wr_en), .wr_addr(d_wr_addr),
        .wr_data(d_wr_data), .rd_addr(d_rd_addr), .rd_data(d_rd_data),
        .dot_cnt(d_dot), .line_cnt(d_line), .frame_cnt(d_frame),
        .vblank(d_vbl), .frame_done(d_fd), .nmi_req(d_nmi)
    );

    // Model state
    int e_dot, e_line, e_frame;
    bit e_flag, e_fd, e_nmi, e_en;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        e_dot = 0; e_line = 0; e_frame = 0;
        e_flag = 0; e_fd = 0; e_nmi = 0; e_en = 0;
    endtask

    function automatic int exp_read(input logic [15:0] a);
        if (a == 16'h4210) return e_flag ? 'h80 : 0;
        if (a == 16'h4212)
            return ((e_line >= SV_LINE) ? 'h80 : 0) |
                   (((e_dot >= SH_START) || (e_dot <= SH_END)) ? 'h40 : 0);
        return 0;
    endfunction

    task automatic compare_all();
        logic [15:0] addrs [4];
        addrs[0] = 16'h4210; addrs[1] = 16'h4212;
        addrs[2] = 16'h4200; addrs[3] = 16'h1234;
        check("R2 dot", int'(dot_cnt), e_dot);
        check("R3 line", int'(line_cnt), e_line);
        check("R3 frame", int'(frame_cnt), e_frame);
        check("R4 vblank", int'(vblank), int'(e_flag));
        check("R5 frame_done", int'(frame_done), int'(e_fd));
        check("R6 nmi_req", int'(nmi_req), int'(e_nmi));
        for (int k = 0; k < 4; k++) begin
            rd_addr = addrs[k];
            #1;
            if (k == 0)      check("R8 nmi status", int'(rd_data), exp_read(addrs[k]));
            else if (k == 1) check("R9 blank status", int'(rd_data), exp_read(addrs[k]));
            else             check("R10 other read", int'(rd_data), exp_read(addrs[k]));
        end
    endtask

    // One clock of the shrunk instance, with an optional write on that edge.
    task automatic step(input bit we, input logic [15:0] wa, input logic [7:0] wd);
        wr_en = we; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        e_fd = 0; e_nmi = 0;
        if (e_dot == SD_LAST) begin
            e_dot = 0;
            e_line++;
            if (e_line == SV_LINE) begin
                e_flag = 1; e_fd = 1; e_nmi = e_en;
            end
            if (e_line == SL_WRAP) begin
                e_flag = 0; e_line = 0; e_frame = (e_frame + 1) % (1 << SF_W);
            end
        end
        e_dot++;
        if (we && wa == 16'h4200) e_en = wd[7];   // R7
        compare_all();
    endtask

    // Step index of the edge that enters the blanking line of frame f.
    function automatic int vbl_edge(input int f);
        return f * STEPS_PER_FRAME + SV_LINE * SD_LAST + 1;
    endfunction

    initial begin
        model_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        check("R1 dot after reset", int'(dot_cnt), 0);
        check("R1 line after reset", int'(line_cnt), 0);
        check("R1 frame after reset", int'(frame_cnt), 0);
        check("R1 vblank after reset", int'(vblank), 0);
        check("R1 pulses after reset", int'(frame_done | nmi_req), 0);
        @(negedge clk);
        rst_n = 1'b1;
        #1;

        // Five frames; writes scheduled onto chosen edges (R6, R7).
        for (int s = 1; s <= 5 * STEPS_PER_FRAME; s++) begin
            if (s == 10)                 step(1'b1, 16'h4201, 8'hFF);  // R7 wrong address
            else if (s == vbl_edge(1))   step(1'b1, 16'h4200, 8'h80);  // R6 enable on the entry edge
            else if (s == 200)           step(1'b1, 16'h4202, 8'h00);  // R7 wrong address
            else if (s == vbl_edge(3))   step(1'b1, 16'h4200, 8'h00);  // R6 disable on the entry edge
            else if (s == 400)           step(1'b1, 16'h4200, 8'h7F);  // R7 only bit 7 counts
            else                         step(1'b0, 16'h0000, 8'h00);
        end

        // Enable, then mid-frame reset: R1 requires the enable to clear too.
        step(1'b1, 16'h4200, 8'h80);
        for (int s = 0; s < 20; s++) step(1'b0, 16'h0000, 8'h00);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_reset();
        check("R1 dot after mid reset", int'(dot_cnt), 0);
        check("R1 line after mid reset", int'(line_cnt), 0);
        check("R1 vblank after mid reset", int'(vblank), 0);
        rst_n = 1'b1;
        for (int s = 1; s <= STEPS_PER_FRAME; s++) step(1'b0, 16'h0000, 8'h00);

        // Default-sized instance at its true event points.
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        d_wr_en = 1'b1; d_wr_addr = 16'h4200; d_wr_data = 8'h80;
        for (int s = 1; s <= 340 * 260 + 1; s++) begin
            @(posedge clk);
            #1;
            d_wr_en = 1'b0;
            if (s == 'h15)  check("R9 default hblank at 0x15", int'(d_rd_data), 'h40);
            if (s == 'h16)  check("R9 default hblank at 0x16", int'(d_rd_data), 'h00);
            if (s == 'h120) check("R9 default hblank at 0x120", int'(d_rd_data), 'h00);
            if (s == 'h121) check("R9 default hblank at 0x121", int'(d_rd_data), 'h40);
            if (s == 341)   check("R2 default dot fold", int'(d_dot), 1);
            if (s == 340 * 225) check("R6 default nmi before entry", int'(d_nmi), 0);
            if (s == 340 * 225 + 1) begin
                check("R6 default nmi at line 225", int'(d_nmi), 1);
                check("R4 default line at entry", int'(d_line), 225);
                check("R9 default both blank bits", int'(d_rd_data), 'hC0);
            end
            if (s == 340 * 260 + 1) begin
                check("R3 default frame wrap", int'(d_frame), 1);
                check("R3 default line wrap", int'(d_line), 0);
                check("R4 default vblank clear", int'(d_vbl), 0);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule